// File: doc/BRIEF.md
# Per-Lane Indexed Constant Waterfall Unit

This block serves ALU instructions that read the 256-entry constant file at an address chosen separately by each lane. An earlier move operation writes every lane's index into a per-lane address register. A later indexed request then resolves those indices. The lanes may disagree on the index, so the unit reads one constant per distinct index. Each value is sent to every active lane that asked for that index, and the unit repeats this until no lane is left waiting. The worst case, with 64 lanes all different, needs 64 reads.

The block also enforces the load-to-use spacing. Two instruction slots must separate an address-register load from the first indexed request that uses it. When the issued stream provides fewer slots, the block adds stall cycles until the spacing is met. A clause-end pulse invalidates the address register. An indexed request made against an invalid register sets a sticky error flag and returns zero to all lanes.

The constant file is external and answers one cycle after a read strobe. Results are held per lane until the next accepted request.

Top module: `cwf_unit`

## Requirements
- R1: After reset, `busy`, `done`, `stall`, `err_flag` and `cf_rd_en` are low and every lane of `res_data` is zero.
- R2: On an address-register load, each lane's index is treated as a two's complement value. Values below 0 are stored as 0 and values above 255 are stored as 255, so `cf_rd_addr` never leaves 0..255.
- R3: An indexed request makes exactly one constant-file read per distinct stored index among the active lanes. The reads are issued in order of the lowest active lane that has not yet been served. Each returned value is written to every active lane holding that index.
- R4: `cf_rd_data` is taken one cycle after the `cf_rd_en` strobe, and two reads are never strobed in consecutive cycles.
- R5: Lanes that are inactive in a request (their `lane_active` bit is 0) read zero in `res_data` once that request completes.
- R6: `busy` rises the cycle after a request is accepted and stays high through a one-cycle `done` pulse. `busy` is low in the cycle after `done`.
- R7: A `req_valid` seen while `busy` is high is refused and starts no later operation.
- R8: `slot_issue` pulses after a load count as separating slots, saturating at two. A request that arrives after g < 2 such slots spends exactly 2 - g cycles with `stall` high before its first read. No read is strobed while `stall` is high.
- R9: After a `clause_end` pulse, a request made before a new load performs no read, returns zero for every lane, still pulses `done`, and sets `err_flag`. `err_flag` then stays high until reset.
- R10: An address-register load requested while `busy` is high is ignored. It changes neither the stored indices nor the slot count.
- R11: A request with no active lanes pulses `done` without any constant-file read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ar_load | input | 1 | Load the per-lane address register |
| ar_lane_idx | input | LANES*IDX_W | Signed index per lane, lane i at bits [i*IDX_W +: IDX_W] |
| clause_end | input | 1 | End of clause; invalidates the address register |
| slot_issue | input | 1 | One unrelated instruction slot was issued |
| req_valid | input | 1 | Indexed constant request |
| lane_active | input | LANES | Active lane mask for the request |
| cf_rd_en | output | 1 | Constant-file read strobe |
| cf_rd_addr | output | AW | Constant-file read address |
| cf_rd_data | input | DATA_W | Constant-file read data, one cycle after the strobe |
| res_data | output | LANES*DATA_W | Per-lane result, lane i at bits [i*DATA_W +: DATA_W] |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| stall | output | 1 | Spacing stall cycle inserted |
| err_flag | output | 1 | Sticky use-after-invalidate error |

## Verification
The hardest state to reach is a request that arrives while an operation is still running, together with a load attempted in the same window. The refused request and the ignored load may leave no visible trace. To expose this, the bench issues a full 64-lane request with divergent indices, then injects both a new request and a load with different indices in mid-operation. It then checks that exactly one `done` appears, that the results follow the original indices, and that a follow-up request runs without a stall. A stall on that follow-up would show that the ignored load had reset the slot count. Separately, the spacing is swept over zero to three intervening slots, and the stall count is compared with 2 - g saturated at zero.

// File: rtl/cwf_pkg.sv
// Shared definitions for the constant waterfall unit.
// Assumes: the spacing requirement fits in a two-bit counter.
package cwf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STALL,
        ST_ISSUE,
        ST_WAIT,
        ST_FIN
    } wf_state_t;

    localparam int unsigned SPACING = 2;
endpackage

// File: rtl/cwf_ar_regs.sv
// Per-lane address register with clamping, a clause-scoped valid bit and
// a load-to-use slot counter that saturates at the required spacing.
// Assumes: IDX_W is wider than AW, so clamping is meaningful.
module cwf_ar_regs #(
    parameter int unsigned LANES    = 64,
    parameter int unsigned IDX_W    = 12,
    parameter int unsigned CF_DEPTH = 256,
    localparam int unsigned AW      = $clog2(CF_DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_en,
    input  logic [LANES*IDX_W-1:0] idx_in,
    input  logic                   clause_end,
    input  logic                   slot_tick,
    output logic [LANES*AW-1:0]    ar_idx,
    output logic                   ar_valid,
    output logic [1:0]             gap
);
    import cwf_pkg::*;

    localparam logic signed [IDX_W-1:0] MAXV = IDX_W'(CF_DEPTH - 1);

    logic [LANES*AW-1:0] clamped;

    // Saturate each lane's signed index into the constant-file range.
    always_comb begin
        for (int i = 0; i < int'(LANES); i++) begin
            logic signed [IDX_W-1:0] v;
            v = $signed(idx_in[i*IDX_W +: IDX_W]);
            if (v[IDX_W-1]) begin
                clamped[i*AW +: AW] = '0;
            end else if (v > MAXV) begin
                clamped[i*AW +: AW] = AW'(CF_DEPTH - 1);
            end else begin
                clamped[i*AW +: AW] = v[AW-1:0];
            end
        end
    end

    // Capture clamped indices on an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_idx <= '0;
        end else if (load_en) begin
            ar_idx <= clamped;
        end
    end

    // Valid for one clause: set by load, cleared by clause end (load wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_valid <= 1'b0;
        end else if (load_en) begin
            ar_valid <= 1'b1;
        end else if (clause_end) begin
            ar_valid <= 1'b0;
        end
    end

    // Count separating slots since the last load, saturating at SPACING.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (load_en) begin
            gap <= '0;
        end else if (slot_tick && (gap < 2'(SPACING))) begin
            gap <= gap + 2'd1;
        end
    end
endmodule

// File: rtl/cwf_picker.sv
// Selects the lowest pending lane, returns its stored index, and flags
// every pending lane holding that same index.
// Assumes: pending is non-zero whenever the result is consumed.
module cwf_picker #(
    parameter int unsigned LANES = 64,
    parameter int unsigned AW    = 8,
    localparam int unsigned LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0]    pending,
    input  logic [LANES*AW-1:0] ar_idx,
    output logic [AW-1:0]       sel_idx,
    output logic [LANES-1:0]    match
);
    logic [LW-1:0] sel_lane;

    // Priority search from the top so the lowest pending lane wins.
    always_comb begin
        sel_lane = '0;
        for (int i = int'(LANES) - 1; i >= 0; i--) begin
            if (pending[i]) begin
                sel_lane = LW'(i);
            end
        end
        sel_idx = ar_idx[sel_lane*AW +: AW];
    end

    // Per-lane comparison against the selected index.
    for (genvar g = 0; g < int'(LANES); g++) begin : g_match
        assign match[g] = pending[g] && (ar_idx[g*AW +: AW] == sel_idx);
    end
endmodule

// File: rtl/cwf_unit.sv
// Indexed constant waterfall: resolves per-lane constant-file indices with
// one read per distinct index, enforces load-to-use spacing by stalling,
// and flags use of an address register invalidated at clause end.
// Assumes: external constant file with fixed one-cycle read latency.
module cwf_unit #(
    parameter int unsigned LANES    = 64,
    parameter int unsigned IDX_W    = 12,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CF_DEPTH = 256,
    localparam int unsigned AW      = $clog2(CF_DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ar_load,
    input  logic [LANES*IDX_W-1:0]  ar_lane_idx,
    input  logic                    clause_end,
    input  logic                    slot_issue,
    input  logic                    req_valid,
    input  logic [LANES-1:0]        lane_active,
    output logic                    cf_rd_en,
    output logic [AW-1:0]           cf_rd_addr,
    input  logic [DATA_W-1:0]       cf_rd_data,
    output logic [LANES*DATA_W-1:0] res_data,
    output logic                    busy,
    output logic                    done,
    output logic                    stall,
    output logic                    err_flag
);
    import cwf_pkg::*;

    wf_state_t           st_q;
    logic [LANES-1:0]    pending_q;
    logic [LANES-1:0]    match_q;
    logic [LANES-1:0]    match;
    logic [LANES-1:0]    pending_after;
    logic [LANES*AW-1:0] ar_idx;
    logic [AW-1:0]       sel_idx;
    logic                ar_valid;
    logic [1:0]          gap;
    logic                accept;

    assign accept        = (st_q == ST_IDLE) && req_valid;
    assign busy          = (st_q != ST_IDLE);
    assign done          = (st_q == ST_FIN);
    assign stall         = (st_q == ST_STALL);
    assign cf_rd_en      = (st_q == ST_ISSUE);
    assign cf_rd_addr    = sel_idx;
    assign pending_after = pending_q & ~match_q;

    cwf_ar_regs #(
        .LANES    (LANES),
        .IDX_W    (IDX_W),
        .CF_DEPTH (CF_DEPTH)
    ) u_ar (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (ar_load && !busy),
        .idx_in     (ar_lane_idx),
        .clause_end (clause_end),
        .slot_tick  (slot_issue || stall),
        .ar_idx     (ar_idx),
        .ar_valid   (ar_valid),
        .gap        (gap)
    );

    cwf_picker #(
        .LANES (LANES),
        .AW    (AW)
    ) u_pick (
        .pending (pending_q),
        .ar_idx  (ar_idx),
        .sel_idx (sel_idx),
        .match   (match)
    );

    // Sequencer: accept, stall for spacing, alternate issue and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (!ar_valid || (lane_active == '0)) begin
                            st_q <= ST_FIN;
                        end else if (gap < 2'(SPACING)) begin
                            st_q <= ST_STALL;
                        end else begin
                            st_q <= ST_ISSUE;
                        end
                    end
                end
                ST_STALL: begin
                    if (gap >= 2'(SPACING - 1)) begin
                        st_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: st_q <= ST_WAIT;
                ST_WAIT: begin
                    st_q <= (pending_after == '0) ? ST_FIN : ST_ISSUE;
                end
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Track lanes still waiting; an invalid register leaves none waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
        end else if (accept) begin
            pending_q <= ar_valid ? lane_active : '0;
        end else if (st_q == ST_WAIT) begin
            pending_q <= pending_after;
        end
    end

    // Remember which lanes the in-flight read belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
        end else if (st_q == ST_ISSUE) begin
            match_q <= match;
        end
    end

    // Sticky error on use of an invalidated address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (accept && !ar_valid) begin
            err_flag <= 1'b1;
        end
    end

    // Per-lane result registers: cleared on accept, filled on capture.
    for (genvar g = 0; g < int'(LANES); g++) begin : g_res
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_data[g*DATA_W +: DATA_W] <= '0;
            end else if (accept) begin
                res_data[g*DATA_W +: DATA_W] <= '0;
            end else if ((st_q == ST_WAIT) && match_q[g]) begin
                res_data[g*DATA_W +: DATA_W] <= cf_rd_data;
            end
        end
    end
endmodule

// File: rtl/cwf_unit_chk.sv
// Port-level temporal checks for cwf_unit, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module cwf_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic stall,
    input logic cf_rd_en,
    input logic err_flag
);
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);                                                    // R6
    AST_DONE_THEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);                                                   // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R6
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);                                         // R7
    AST_READ_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        cf_rd_en |=> !cf_rd_en);                                           // R4
    AST_NO_READ_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !cf_rd_en);                                              // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);                                            // R9
endmodule

bind cwf_unit cwf_unit_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .stall    (stall),
    .cf_rd_en (cf_rd_en),
    .err_flag (err_flag)
);

// File: tb/cwf_unit_tb_top.sv
// Self-checking bench for cwf_unit with arithmetic constant-file model.
module cwf_unit_tb_top;
    localparam int L  = 64;
    localparam int IW = 12;
    localparam int DW = 32;
    localparam int AW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ar_load = 1'b0;
    logic [L*IW-1:0]   ar_lane_idx = '0;
    logic              clause_end = 1'b0;
    logic              slot_issue = 1'b0;
    logic              req_valid = 1'b0;
    logic [L-1:0]      lane_active = '0;
    logic              cf_rd_en;
    logic [AW-1:0]     cf_rd_addr;
    logic [DW-1:0]     cf_rd_data = '0;
    logic [L*DW-1:0]   res_data;
    logic              busy, done, stall, err_flag;

    int n_checks = 0;
    int n_errors = 0;
    int idx_arr[L];
    int rd_log[128];
    int rd_n = 0, stall_n = 0, done_n = 0, b2b_n = 0;
    bit prev_rd = 1'b0;

    always #5 clk = ~clk;

    cwf_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ar_load(ar_load), .ar_lane_idx(ar_lane_idx),
        .clause_end(clause_end), .slot_issue(slot_issue), .req_valid(req_valid),
        .lane_active(lane_active), .cf_rd_en(cf_rd_en), .cf_rd_addr(cf_rd_addr),
        .cf_rd_data(cf_rd_data), .res_data(res_data), .busy(busy), .done(done),
        .stall(stall), .err_flag(err_flag)
    );

    function automatic logic [DW-1:0] cval(int a);
        return DW'(a * 40503 + 32'h1357_0000 + 7);
    endfunction

    function automatic int clampv(int v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    // Constant-file model with one-cycle read latency.
    always @(posedge clk) if (cf_rd_en) cf_rd_data <= cval(int'(cf_rd_addr));

    // Monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (cf_rd_en) begin
            if (rd_n < 128) rd_log[rd_n] = int'(cf_rd_addr);
            rd_n++;
            if (prev_rd) b2b_n++;
        end
        prev_rd = cf_rd_en;
        if (stall) stall_n++;
        if (done) done_n++;
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load_ar(int gaps);
        @(negedge clk);
        for (int i = 0; i < L; i++) ar_lane_idx[i*IW +: IW] = IW'(idx_arr[i]);
        ar_load = 1'b1;
        @(negedge clk);
        ar_load = 1'b0;
        for (int k = 0; k < gaps; k++) begin
            slot_issue = 1'b1;
            @(negedge clk);
            slot_issue = 1'b0;
        end
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(t < 2000, "R6", "done seen", t, 0);
        check(busy == 1'b1, "R6", "busy during done", busy, 1);
        @(negedge clk);
        check(busy == 1'b0, "R6", "busy after done", busy, 0);
    endtask

    task automatic run_op(logic [L-1:0] mask);
        @(negedge clk);
        rd_n = 0; stall_n = 0; done_n = 0; b2b_n = 0;
        req_valid = 1'b1;
        lane_active = mask;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R6", "busy after accept", busy, 1);
        wait_done();
    endtask

    // Compare reads, order, results and stalls against the requirements.
    task automatic verify(logic [L-1:0] mask, int exp_stall, string areq);
        int exp_list[64];
        int n = 0;
        for (int i = 0; i < L; i++) begin
            if (mask[i]) begin
                bit seen = 1'b0;
                for (int j = 0; j < n; j++) if (exp_list[j] == clampv(idx_arr[i])) seen = 1'b1;
                if (!seen) begin
                    exp_list[n] = clampv(idx_arr[i]);
                    n++;
                end
            end
        end
        check(rd_n == n, "R3", "read count", rd_n, n);
        for (int j = 0; j < n && j < rd_n; j++)
            check(rd_log[j] == exp_list[j], areq, "read address order", rd_log[j], exp_list[j]);
        for (int i = 0; i < L; i++) begin
            logic [DW-1:0] e = mask[i] ? cval(clampv(idx_arr[i])) : '0;
            check(res_data[i*DW +: DW] == e, mask[i] ? "R3" : "R5", "lane result",
                  res_data[i*DW +: DW], e);
        end
        check(stall_n == exp_stall, "R8", "stall cycles", stall_n, exp_stall);
        check(done_n == 1, "R6", "done pulses", done_n, 1);
        check(b2b_n == 0, "R4", "back-to-back reads", b2b_n, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !stall && !err_flag && !cf_rd_en, "R1", "control outputs",
              {busy, done, stall, err_flag, cf_rd_en}, 0);
        check(res_data == '0, "R1", "results zero", res_data[DW-1:0], 0);

        // R3 all lanes share one index: single read
        for (int i = 0; i < L; i++) idx_arr[i] = 37;
        load_ar(2); run_op('1); verify('1, 0, "R3");

        // R3 all distinct ascending: 64 reads
        for (int i = 0; i < L; i++) idx_arr[i] = i * 3;
        load_ar(2); run_op('1); verify('1, 0, "R3");

        // R3 all distinct descending: order follows lowest lane
        for (int i = 0; i < L; i++) idx_arr[i] = 200 - i;
        load_ar(2); run_op('1); verify('1, 0, "R3");

        // R5 alternate lanes active with four index groups
        for (int i = 0; i < L; i++) idx_arr[i] = (i % 4) + 10;
        load_ar(2); run_op({32{2'b01}}); verify({32{2'b01}}, 0, "R3");

        // R2 clamping of negative and oversized indices
        for (int i = 0; i < L; i++) idx_arr[i] = i * 11 - 200;
        load_ar(2); run_op('1); verify('1, 0, "R2");

        // R11 empty mask
        load_ar(2); run_op('0);
        check(rd_n == 0, "R11", "no reads on empty mask", rd_n, 0);
        check(done_n == 1, "R11", "done on empty mask", done_n, 1);

        // R8 spacing sweep over intervening slots
        for (int g = 0; g < 4; g++) begin
            for (int i = 0; i < L; i++) idx_arr[i] = (i * 7 + g) % 5;
            load_ar(g); run_op('1);
            verify('1, (g < 2) ? 2 - g : 0, "R3");
        end

        // R7 / R10 request and load injected while busy
        for (int i = 0; i < L; i++) idx_arr[i] = i;
        load_ar(2);
        @(negedge clk);
        rd_n = 0; stall_n = 0; done_n = 0; b2b_n = 0;
        req_valid = 1'b1; lane_active = '1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < L; i++) ar_lane_idx[i*IW +: IW] = IW'(99);
        req_valid = 1'b1; ar_load = 1'b1; lane_active = 64'h1;
        @(negedge clk);
        req_valid = 1'b0; ar_load = 1'b0; lane_active = '1;
        wait_done();
        verify('1, 0, "R7");
        repeat (4) @(negedge clk);
        check(busy == 1'b0 && done_n == 1, "R7", "refused request stayed idle", busy, 0);
        run_op('1);
        verify('1, 0, "R10");

        check(err_flag == 1'b0, "R9", "no error before invalidation", err_flag, 0);

        // R9 clause end invalidates: error, zero results, no reads
        @(negedge clk);
        clause_end = 1'b1;
        @(negedge clk);
        clause_end = 1'b0;
        run_op('1);
        check(rd_n == 0, "R9", "no reads when invalid", rd_n, 0);
        check(res_data == '0, "R9", "zero results when invalid", res_data[DW-1:0], 0);
        check(err_flag == 1'b1, "R9", "error flag set", err_flag, 1);
        check(done_n == 1, "R9", "done on invalid use", done_n, 1);

        // R9 error remains sticky across a valid operation
        for (int i = 0; i < L; i++) idx_arr[i] = 255 - (i % 3);
        load_ar(2); run_op('1); verify('1, 0, "R3");
        check(err_flag == 1'b1, "R9", "error flag sticky", err_flag, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule